// File: doc/BRIEF.md
# Per-core private interrupt enable register

This block holds the forwarding enables for the 32 interrupts that are private to one core. Bits 15:0 belong to the 16 software-generated interrupts and bits 31:16 to the 16 private peripheral interrupts. Bit i always corresponds to interrupt i. The forwarding logic downstream receives the whole enable vector as a plain 32-bit output.

Software reaches the enables through a small register port. A write to the set window turns on each enable whose data bit is 1. A write to the clear window turns off each enable whose data bit is 1. Reading either window returns the current enable vector. An enable bit can be hidden from a given access. In that case it reads as zero and ignores writes. This happens when affinity routing is off for the security state of that interrupt. It also happens when a non-secure access reaches a secure interrupt while the security-disable control is low.

Top module: `core_irq_enable_reg`

## Requirements
- R1: An active-low synchronous reset clears every enable bit and drives read data to zero.
- R2: A write at offset 0x100 sets each enable bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: A write at offset 0x180 clears each enable bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: A read at offset 0x100 or 0x180 returns the visible enable bits on rd_data in the cycle after rd_en. When no read occurs, rd_data is zero in the following cycle.
- R5: Output bit irq_enable[i] reflects the stored enable of interrupt i. Both the SGI range (bits 15:0) and the PPI range (bits 31:16) are covered.
- R6: Bit i is hidden when affinity routing is off for its security state. The state is secure when irq_secure[i] is 1, which selects ar_en_sec; otherwise it selects ar_en_nsec. A hidden bit reads as zero, and writes to it do not change it.
- R7: When sec_disable is 0, a non-secure access (acc_ns=1) hides every bit with irq_secure[i]=1. When sec_disable is 1, the same access is not restricted.
- R8: Accesses at any other offset read zero and leave every enable bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Byte offset within the per-core frame |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| acc_ns | input | 1 | Access is non-secure |
| rd_data | output | 32 | Registered read data |
| irq_secure | input | 32 | Per-interrupt group: 1 = secure |
| sec_disable | input | 1 | 1 = single security state, no non-secure restriction |
| ar_en_sec | input | 1 | Affinity routing enabled for the secure state |
| ar_en_nsec | input | 1 | Affinity routing enabled for the non-secure state |
| irq_enable | output | 32 | Enable vector sent to the forwarding logic |

## Verification
Set and clear writes use sparse, dense, alternating and single-bit patterns. The single-bit patterns land in both the SGI and PPI halves, which shows that zeros in the write data do not disturb neighbouring bits and that no range is miswired. Each visibility condition is exercised with a mixed secure/non-secure group vector: affinity routing off per state, and non-secure access with the security-disable control low and then high. This separates the two masking conditions from each other and from the group selection. Accesses at an unmapped offset and cycles with no read confirm the zero read data and the unchanged state.

// File: rtl/core_irq_enable_reg.sv
module core_irq_enable_reg #(
  parameter int ADDR_W  = 12,
  parameter int N_IRQ   = 32,
  parameter logic [ADDR_W-1:0] SET_OFS = 12'h100,
  parameter logic [ADDR_W-1:0] CLR_OFS = 12'h180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [N_IRQ-1:0]  wr_data,
  input  logic              acc_ns,
  output logic [N_IRQ-1:0]  rd_data,
  input  logic [N_IRQ-1:0]  irq_secure,
  input  logic              sec_disable,
  input  logic              ar_en_sec,
  input  logic              ar_en_nsec,
  output logic [N_IRQ-1:0]  irq_enable
);

  logic [N_IRQ-1:0] en_q, visible, set_v, clr_v;
  logic             hit_set, hit_clr;

  assign hit_set = addr == SET_OFS;
  assign hit_clr = addr == CLR_OFS;

  // Routing gate per state, then the non-secure restriction on secure bits.
  assign visible = (irq_secure & {N_IRQ{ar_en_sec}} | ~irq_secure & {N_IRQ{ar_en_nsec}})
                 & ~(irq_secure & {N_IRQ{acc_ns & ~sec_disable}});

  assign set_v = (wr_en && hit_set) ? wr_data & visible : '0;
  assign clr_v = (wr_en && hit_clr) ? wr_data & visible : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      rd_data <= '0;
    end else begin
      en_q    <= (en_q & ~clr_v) | set_v;
      rd_data <= (rd_en && (hit_set || hit_clr)) ? en_q & visible : '0;
    end
  end

  assign irq_enable = en_q;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_set) |=> ((irq_enable & $past(wr_data & visible)) == $past(wr_data & visible)));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_clr) |=> ((irq_enable & $past(wr_data & visible)) == '0));

  p_idle_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));

  p_hidden_wi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((irq_enable ^ $past(irq_enable)) & ~$past(visible)) == '0));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (hit_set || hit_clr)) |=> $stable(irq_enable));

endmodule

// File: tb/sim_core_irq_enable_reg.sv
module sim_core_irq_enable_reg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] addr = '0;
  logic        wr_en = 0, rd_en = 0, acc_ns = 0;
  logic [31:0] wr_data = '0, irq_secure = '0;
  logic        sec_disable = 1, ar_en_sec = 1, ar_en_nsec = 1;
  logic [31:0] rd_data, irq_enable;

  core_irq_enable_reg u0 (.*);

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  string tag = "R1";
  bit [31:0] m_en = 0, m_rd = 0;

  function automatic bit [31:0] vis_of(bit [31:0] sec, bit sd, bit ars, bit arn, bit ns);
    bit [31:0] v;
    for (int i = 0; i < 32; i++) begin
      bit ok;
      ok = sec[i] ? ars : arn;
      if (ns && !sd && sec[i]) ok = 0;
      v[i] = ok;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    bit [31:0] v;
    v = vis_of(irq_secure, sec_disable, ar_en_sec, ar_en_nsec, acc_ns);
    if (!rst_n) begin
      m_en = 0; m_rd = 0;
    end else begin
      m_rd = (rd_en && (addr == 12'h100 || addr == 12'h180)) ? (m_en & v) : 0;
      if (wr_en && addr == 12'h100) m_en = m_en | (wr_data & v);
      else if (wr_en && addr == 12'h180) m_en = m_en & ~(wr_data & v);
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (irq_enable !== m_en) begin
      fails++;
      $display("FAIL %s irq_enable actual=%h expected=%h", tag, irq_enable, m_en);
    end
    if (rd_data !== m_rd) begin
      fails++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, m_rd);
    end
  end

  task automatic acc(input string t, input bit w, input bit [11:0] a, input bit [31:0] d);
    @(posedge clk); #1;
    tag = t; wr_en = w; rd_en = !w; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    acc("R1", 0, 12'h100, 0);
    // R2: sparse, dense, single bits in both halves
    acc("R2", 1, 12'h100, 32'h0000_0001);
    acc("R5", 1, 12'h100, 32'h0010_0000);
    acc("R4", 0, 12'h100, 0);
    acc("R2", 1, 12'h100, 32'hA5A5_0F0F);
    acc("R4", 0, 12'h180, 0);
    acc("R2", 1, 12'h100, 32'h0);
    // R3: clear patterns
    acc("R3", 1, 12'h180, 32'h5555_5555);
    acc("R3", 1, 12'h180, 32'h0);
    acc("R4", 0, 12'h100, 0);
    acc("R3", 1, 12'h180, 32'hFFFF_FFFF);
    acc("R2", 1, 12'h100, 32'hFFFF_FFFF);
    // R8: unmapped offsets
    acc("R8", 1, 12'h104, 32'hFFFF_FFFF);
    acc("R8", 1, 12'h000, 32'h0);
    acc("R8", 0, 12'h17C, 0);
    // R6: routing off per state, mixed groups
    irq_secure = 32'hF0F0_3C3C;
    ar_en_sec = 0;
    acc("R6", 0, 12'h100, 0);
    acc("R6", 1, 12'h180, 32'hFFFF_FFFF);
    acc("R6", 0, 12'h100, 0);
    ar_en_sec = 1; ar_en_nsec = 0;
    acc("R6", 0, 12'h180, 0);
    acc("R6", 1, 12'h100, 32'hFFFF_FFFF);
    acc("R6", 1, 12'h180, 32'h0F0F_0F0F);
    ar_en_nsec = 1;
    acc("R6", 0, 12'h100, 0);
    // R7: non-secure access restriction
    acc("R7", 1, 12'h100, 32'hFFFF_FFFF);
    acc_ns = 1; sec_disable = 0;
    acc("R7", 0, 12'h100, 0);
    acc("R7", 1, 12'h180, 32'hFFFF_FFFF);
    acc("R7", 0, 12'h180, 0);
    acc_ns = 0;
    acc("R7", 0, 12'h100, 0);
    acc_ns = 1; sec_disable = 1;
    acc("R7", 1, 12'h180, 32'hFFFF_0000);
    acc("R7", 0, 12'h100, 0);
    acc_ns = 0;
    // R1: reset again from a loaded state
    acc("R1", 1, 12'h100, 32'h1234_5678);
    @(posedge clk); #1; tag = "R1"; rst_n = 0; rd_en = 1; addr = 12'h100;
    repeat (2) @(posedge clk);
    #1; rst_n = 1; rd_en = 0;
    acc("R1", 0, 12'h100, 0);
    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule